// File: doc/BRIEF.md
# Half-Rate Symbol-Spaced Tap Generator

This block feeds the taps of a transmit FIR pre-emphasis filter. A serial bit stream arrives as two half-rate lanes. On each half-rate beat the even lane holds the earlier symbol and the odd lane holds the later one. The block returns five copies of that stream. Tap j is the stream delayed by exactly j symbol periods, and every tap is also presented as an even/odd pair per beat. Every register runs on the half-rate clock alone.

Each delay stage is a pair of registers, one per lane. The stage outputs feed the next stage's inputs directly. An even-numbered tap reads a stage's two registers in their natural order. An odd-numbered tap crosses over: its earlier slot comes from the later lane of the next stage, and its later slot comes from the earlier lane of the current stage. A chain of three stages therefore gives five taps that are one symbol apart.

The pair stream passes through a valid/ready interface. An accepted input pair shifts the whole chain by two symbols and produces exactly one output beat. When no pair is accepted, every stage holds its value. When the output is held back, the input is stalled. The block holds no storage beyond the delay chain, so only one output beat can be pending at a time.

Top module: `sst_tap_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every stage register and `out_valid`. On the cycle after reset, all bits of `tap_even` and `tap_odd` read 0.
- R2: After an accepted beat, `tap_even[0]` equals the accepted `in_even` and `tap_odd[0]` equals the accepted `in_odd`.
- R3: For j ≥ 1, after an accepted beat, `tap_even[j]` equals the value `tap_odd[j-1]` held before that beat. The later symbol of one beat moves into the earlier slot of the next beat.
- R4: For j ≥ 1, `tap_odd[j]` always equals `tap_even[j-1]` in the same cycle. The earlier slot moves into the later slot of the next tap within one beat.
- R5: Write the full-rate stream as x, with symbol 2k in `in_even` and symbol 2k+1 in `in_odd` of accepted beat k. After that beat, `tap_even[j]` = x[2k−j] and `tap_odd[j]` = x[2k+1−j]. Symbols from before the last reset read 0.
- R6: A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when `out_ready` is high or `out_valid` is low.
- R7: In a cycle with no accepted beat, no tap output changes, whatever data the lanes carry.
- R8: `out_valid` rises after an accepted beat and stays high until `out_ready` takes it. It falls when the beat is taken and no new beat is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Input pair can be taken this cycle |
| in_even | input | 1 | Earlier symbol of the pair |
| in_odd | input | 1 | Later symbol of the pair |
| out_valid | output | 1 | Tap pairs hold an untaken beat |
| out_ready | input | 1 | Consumer takes the beat |
| tap_even | output | NTAPS | Earlier-slot bit of each tap, bit j = tap j |
| tap_odd | output | NTAPS | Later-slot bit of each tap, bit j = tap j |

## Verification
The bench compares every beat with a full-rate reference shift register over a complete 2^15−1 PRBS period. A swap of the crossover on odd taps would show up as a two-symbol slip or as reversed slots on taps 1 and 3. After reset, all 64 three-beat patterns run from a clean state. These catch stages that fail to clear, and taps that fill with stale data rather than zeros. A pseudo-random valid/ready phase stalls both sides. A design that shifts on `in_valid` alone, or that drops `out_valid` while the consumer is stalled, would lose or repeat symbols.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned SST_DEF_TAPS = 5;

  function automatic int unsigned sst_stage_count(input int unsigned taps);
    return taps / 2 + 1;
  endfunction
endpackage

// File: rtl/sst_flow_ctl.sv
module sst_flow_ctl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic advance
);
  logic pend_q;

  assign in_ready  = out_ready | ~pend_q;
  assign advance   = in_valid & in_ready;
  assign out_valid = pend_q;

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (advance)   pend_q <= 1'b1;
    else if (out_ready) pend_q <= 1'b0;
  end
endmodule

// File: rtl/sst_hr_stage.sv
module sst_hr_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d_early,
  input  logic d_late,
  output logic q_early,
  output logic q_late
);
  // two flops standing for the opposite-phase capture pair of one stage
  always_ff @(posedge clk) begin
    if (rst) begin
      q_early <= 1'b0;
      q_late  <= 1'b0;
    end else if (en) begin
      q_early <= d_early;
      q_late  <= d_late;
    end
  end
endmodule

// File: rtl/sst_tap_gen.sv
module sst_tap_gen #(
  parameter int unsigned NTAPS = sst_pkg::SST_DEF_TAPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_even,
  input  logic             in_odd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NTAPS-1:0] tap_even,
  output logic [NTAPS-1:0] tap_odd
);
  localparam int unsigned NSTG = sst_pkg::sst_stage_count(NTAPS);

  logic            advance;
  logic [NSTG-1:0] stg_e;
  logic [NSTG-1:0] stg_o;

  sst_flow_ctl u_flow (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .advance   (advance)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic de, dl;
    if (s == 0) begin : g_head
      assign de = in_even;
      assign dl = in_odd;
    end else begin : g_link
      assign de = stg_e[s-1];
      assign dl = stg_o[s-1];
    end
    sst_hr_stage u_stg (
      .clk     (clk),
      .rst     (rst),
      .en      (advance),
      .d_early (de),
      .d_late  (dl),
      .q_early (stg_e[s]),
      .q_late  (stg_o[s])
    );
  end

  // interleaved output select: even taps read one stage straight,
  // odd taps straddle a stage and its successor
  for (genvar j = 0; j < NTAPS; j++) begin : g_tap
    localparam int unsigned S = j / 2;
    if (j % 2 == 0) begin : g_straight
      assign tap_even[j] = stg_e[S];
      assign tap_odd[j]  = stg_o[S];
    end else begin : g_cross
      assign tap_even[j] = stg_o[S+1];
      assign tap_odd[j]  = stg_e[S];
    end
  end
endmodule

// File: rtl/sst_tap_gen_chk.sv
module sst_tap_gen_chk #(
  parameter int unsigned NTAPS = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_even,
  input logic             in_odd,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NTAPS-1:0] tap_even,
  input logic [NTAPS-1:0] tap_odd
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && tap_even == '0 && tap_odd == '0));

  // R2
  head_load_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (tap_even[0] == $past(in_even) && tap_odd[0] == $past(in_odd)));

  for (genvar j = 1; j < NTAPS; j++) begin : g_tapchk
    // R3
    beat_carry_chk: assert property (@(posedge clk) disable iff (rst)
      acc |=> (tap_even[j] == $past(tap_odd[j-1])));
    // R4
    slot_carry_chk: assert property (@(posedge clk) disable iff (rst)
      tap_odd[j] == tap_even[j-1]);
  end

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  hold_taps_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(tap_even) && $stable(tap_odd)));

  // R8
  valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  // R8
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind sst_tap_gen sst_tap_gen_chk #(.NTAPS(NTAPS)) u_chk (.*);

// File: tb/sim_sst_tap_gen.sv
`timescale 1ns/1ps
module sim_sst_tap_gen;
  localparam int NT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_even = 1'b0, in_odd = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [NT-1:0] tap_even, tap_odd;

  sst_tap_gen #(.NTAPS(NT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
    .out_ready(out_ready), .tap_even(tap_even), .tap_odd(tap_odd)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] ref_sr = '0;
  logic m_ov = 1'b0;
  logic [14:0] prbs = 15'h7FFF;
  logic [14:0] hs = 15'h1234;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic prbs_bit();
    logic b;
    b = prbs[14] ^ prbs[13];
    prbs = {prbs[13:0], b};
    return b;
  endfunction

  function automatic logic hs_bit();
    logic b;
    b = hs[14] ^ hs[13];
    hs = {hs[13:0], b};
    return b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(posedge clk); #1;
    // R1
    chk(out_valid == 1'b0, "R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk(tap_even == '0 && tap_odd == '0, "R1 taps", {3'd0, tap_even, 3'd0, tap_odd}, 16'd0);
    ref_sr = '0; m_ov = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic e, input logic o, input logic r);
    logic exp_rdy, fire;
    logic [NT-1:0] xe, xo;
    @(negedge clk);
    in_valid = v; in_even = e; in_odd = o; out_ready = r;
    #1;
    exp_rdy = r || !m_ov;
    // R6
    chk(in_ready == exp_rdy, "R6 in_ready", {15'd0, in_ready}, {15'd0, exp_rdy});
    fire = v && exp_rdy;
    @(posedge clk);
    if (fire) begin
      ref_sr = {ref_sr[13:0], e, o};
      m_ov = 1'b1;
    end else if (r) begin
      m_ov = 1'b0;
    end
    #1;
    // R8
    chk(out_valid == m_ov, "R8 out_valid", {15'd0, out_valid}, {15'd0, m_ov});
    for (int j = 0; j < NT; j++) begin
      xe[j] = ref_sr[j+1];
      xo[j] = ref_sr[j];
    end
    if (!fire) begin
      // R7
      chk(tap_even == xe && tap_odd == xo, "R7 hold", {3'd0, tap_even, 3'd0, tap_odd}, {3'd0, xe, 3'd0, xo});
    end else begin
      // R2
      chk(tap_even[0] == xe[0] && tap_odd[0] == xo[0], "R2 tap0", {14'd0, tap_even[0], tap_odd[0]}, {14'd0, xe[0], xo[0]});
      // R3
      chk(tap_even[NT-1:1] == xe[NT-1:1], "R3 even slots", {12'd0, tap_even[NT-1:1]}, {12'd0, xe[NT-1:1]});
      // R4
      chk(tap_odd[NT-1:1] == xo[NT-1:1], "R4 odd slots", {12'd0, tap_odd[NT-1:1]}, {12'd0, xo[NT-1:1]});
      // R5
      chk(tap_even == xe && tap_odd == xo, "R5 delay line", {3'd0, tap_even, 3'd0, tap_odd}, {3'd0, xe, 3'd0, xo});
    end
  endtask

  initial begin
    do_reset();
    // full PRBS period, streaming at one beat per cycle
    for (int k = 0; k < 16384; k++) begin
      logic a, b;
      a = prbs_bit();
      b = prbs_bit();
      step(1'b1, a, b, 1'b1);
    end
    // pseudo-random back-pressure on both sides
    for (int k = 0; k < 6000; k++) begin
      logic a, b, v, r;
      a = prbs_bit();
      b = prbs_bit();
      v = hs_bit() | hs_bit();
      r = hs_bit();
      step(v, a, b, r);
    end
    // every three-beat pattern from a clean reset (R5 zero fill)
    for (int p = 0; p < 64; p++) begin
      do_reset();
      for (int k = 0; k < 3; k++) begin
        step(1'b1, p[2*k], p[2*k+1], 1'b1);
      end
      step(1'b0, 1'b1, 1'b1, 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule